// File: doc/BRIEF.md
# Bit Test and Clear Execution Unit

This unit carries out the single-bit test and single-bit clear instructions of a processor with 16-bit opcodes and 32-bit data registers. A command carries the opcode, the bit-number source (the contents of the selected data register for the dynamic form, or the extension word for the immediate form), the current destination register value and the condition-code bits. The unit decodes the command and picks the selected bit. It reports the zero flag and, for a clear, writes back the operand with that bit forced to 0. For a memory destination it fetches one byte over a read stream and, for a clear, returns the modified byte over a write stream. Address generation and the bus itself sit outside the unit. The unit only tells the caller which address register to step and in which direction.

Commands, read bytes and write bytes use valid/ready streams with these back-pressure rules. A transfer happens on a rising clock edge where valid and ready are both high. `cmd_ready` is high only while the unit is idle, so the caller keeps a command steady until it is taken. `mem_rd_ready` is high only while the unit waits for its operand byte. Once `mem_wr_valid` rises, it and `mem_wr_data` hold steady until `mem_wr_ready` takes the byte. Results appear for exactly one cycle, marked by `done`.

Top module: `bit_clear_unit`

## Requirements
- R1: An opcode is accepted as a dynamic form when (opcode & 0xF1C0) equals 0x0100 (test) or 0x0180 (clear), and as an immediate form when (opcode & 0xFFC0) equals 0x0800 (test) or 0x0880 (clear). Any other opcode completes with `illegal` high, performs no access, and has no effect on the register, the address register or the flags.
- R2: The destination mode is opcode bits 5:3 and the destination register is bits 2:0. Mode 000 is a data register and every other mode except 001 is memory. Mode 001 completes with `illegal` high and has no side effect: no memory access, `reg_wr_en` low, `an_adj_en` low, and `ccr_out` equal to `cmd_ccr`.
- R3: For a data-register destination, the bit number is `cmd_bitsrc` modulo 32. A clear raises `reg_wr_en` in the `done` cycle, with `reg_wr_idx` set to opcode bits 2:0 and `reg_wr_data` equal to the register value with that bit set to 0. A test never raises `reg_wr_en`.
- R4: For a memory destination, the bit number is `cmd_bitsrc` modulo 8. A test makes exactly one byte read and no write. A clear makes one read and then one write of the read byte with the selected bit set to 0.
- R5: `ccr_out` bit 2 (zero) is 1 exactly when the selected bit was 0 before any change. Bits 4, 3, 1 and 0 of `ccr_out` equal those of `cmd_ccr`.
- R6: In the `done` cycle, `step_len` is 8 for a clear on a data register with bit number modulo 32 below 16, and 12 when it is 16 or above. It is 0 for every other command.
- R7: Mode 011 raises `an_adj_en` with `an_adj_dec` low, and mode 100 raises it with `an_adj_dec` high, both with `an_adj_idx` equal to opcode bits 2:0, for a step of one byte. No other mode raises `an_adj_en`.
- R8: The stream rules above hold. In particular, `mem_wr_data` does not change while `mem_wr_valid` is high and `mem_wr_ready` is low.
- R9: `done` is a one-cycle pulse. For a register destination or an illegal command, it comes in the cycle after the command is accepted. `reg_wr_en` and `an_adj_en` are never high outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and taking a command |
| cmd_opcode | input | 16 | Instruction opcode word |
| cmd_bitsrc | input | 32 | Bit-number source (register contents or extension word) |
| cmd_dreg | input | 32 | Current value of the destination data register |
| cmd_ccr | input | 5 | Condition codes {X,N,Z,V,C} before the instruction |
| mem_rd_valid | input | 1 | Operand byte offered |
| mem_rd_ready | output | 1 | Unit waiting for the operand byte |
| mem_rd_data | input | 8 | Operand byte read from memory |
| mem_wr_valid | output | 1 | Write-back byte offered |
| mem_wr_ready | input | 1 | Write-back byte taken |
| mem_wr_data | output | 8 | Byte to write back |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Encoding rejected (valid with done) |
| reg_wr_en | output | 1 | Data register write strobe |
| reg_wr_idx | output | 3 | Data register to write |
| reg_wr_data | output | 32 | Value to write to the data register |
| ccr_out | output | 5 | Condition codes after the instruction |
| step_len | output | 4 | Internal step length in half-clock units |
| an_adj_en | output | 1 | Address register step request |
| an_adj_dec | output | 1 | 1 for decrement, 0 for increment |
| an_adj_idx | output | 3 | Address register to step |

## Verification
In the `done` cycle of a register clear, the zero-flag update and the write-back happen together. The flag must describe the bit before it was cleared, while `reg_wr_data` already has it cleared. Every bit number from 0 to 63 is driven against operands whose selected bit is sometimes 1 and sometimes 0, so both orderings of that pair are exposed. Each completion is judged against a mask computed in the bench. Memory clears run the same pairing over the read and write streams, with random stalls on both to test stability under back-pressure.

// File: rtl/btc_pkg.sv
package btc_pkg;

  localparam logic [15:0] DYN_MASK = 16'hF1C0;
  localparam logic [15:0] DYN_TST  = 16'h0100;
  localparam logic [15:0] DYN_CLR  = 16'h0180;
  localparam logic [15:0] IMM_MASK = 16'hFFC0;
  localparam logic [15:0] IMM_TST  = 16'h0800;
  localparam logic [15:0] IMM_CLR  = 16'h0880;

  localparam logic [2:0] MODE_DREG    = 3'b000;
  localparam logic [2:0] MODE_AREG    = 3'b001;
  localparam logic [2:0] MODE_POSTINC = 3'b011;
  localparam logic [2:0] MODE_PREDEC  = 3'b100;

  localparam int CCR_W = 5;
  localparam int ZBIT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } btc_state_e;

  typedef struct packed {
    logic       illegal;
    logic       is_clr;
    logic       is_mem;
    logic [2:0] mode;
    logic [2:0] ea_reg;
  } btc_dec_t;

endpackage

// File: rtl/btc_decode.sv
module btc_decode
  import btc_pkg::*;
(
  input  logic [15:0] opcode,
  output btc_dec_t    dec
);
  logic dyn_hit;
  logic imm_hit;

  always_comb begin
    dyn_hit = ((opcode & DYN_MASK) == DYN_TST) || ((opcode & DYN_MASK) == DYN_CLR);
    imm_hit = ((opcode & IMM_MASK) == IMM_TST) || ((opcode & IMM_MASK) == IMM_CLR);
    dec.mode    = opcode[5:3];
    dec.ea_reg  = opcode[2:0];
    // bit 7 separates clear from test in both forms
    dec.is_clr  = opcode[7];
    dec.is_mem  = (opcode[5:3] != MODE_DREG);
    dec.illegal = !(dyn_hit || imm_hit) || (opcode[5:3] == MODE_AREG);
  end
endmodule

// File: rtl/btc_bitop.sv
module btc_bitop #(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int BASE_HALF = 8,
  parameter int HI_EXTRA  = 4,
  parameter int STEP_W    = 4
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bitsrc,
  input  logic              is_mem,
  input  logic              is_clr,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic [STEP_W-1:0] step_len
);
  localparam int REG_IDX_W = $clog2(DATA_W);
  localparam int MEM_IDX_W = $clog2(BYTE_W);

  logic [REG_IDX_W-1:0] idx;
  logic [DATA_W-1:0]    mask;

  always_comb begin
    if (is_mem) idx = REG_IDX_W'(bitsrc[MEM_IDX_W-1:0]);
    else        idx = bitsrc[REG_IDX_W-1:0];
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx == REG_IDX_W'(g));
  end

  always_comb begin
    zero   = ~|(operand & mask);
    result = is_clr ? (operand & ~mask) : operand;
    if (is_clr && !is_mem)
      step_len = STEP_W'(BASE_HALF) + (idx[REG_IDX_W-1] ? STEP_W'(HI_EXTRA) : '0);
    else
      step_len = '0;
  end
endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  logic     rd_valid,
  input  logic     wr_ready,
  input  btc_dec_t new_dec,
  input  btc_dec_t cur_dec,
  output logic     cmd_ready,
  output logic     rd_ready,
  output logic     wr_valid,
  output logic     done
);
  btc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:
        if (cmd_valid) begin
          if (new_dec.illegal || !new_dec.is_mem) state_d = ST_DONE;
          else                                    state_d = ST_READ;
        end
      ST_READ:
        if (rd_valid) state_d = cur_dec.is_clr ? ST_WRITE : ST_DONE;
      ST_WRITE:
        if (wr_ready) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign rd_ready  = (state_q == ST_READ);
  assign wr_valid  = (state_q == ST_WRITE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/bit_clear_unit.sv
module bit_clear_unit
  import btc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int BASE_HALF = 8,
  parameter int HI_EXTRA  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_opcode,
  input  logic [DATA_W-1:0] cmd_bitsrc,
  input  logic [DATA_W-1:0] cmd_dreg,
  input  logic [4:0]        cmd_ccr,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [BYTE_W-1:0] mem_wr_data,
  output logic              done,
  output logic              illegal,
  output logic              reg_wr_en,
  output logic [2:0]        reg_wr_idx,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [4:0]        ccr_out,
  output logic [3:0]        step_len,
  output logic              an_adj_en,
  output logic              an_adj_dec,
  output logic [2:0]        an_adj_idx
);
  localparam int STEP_W = 4;

  btc_dec_t          dec_in;
  btc_dec_t          dec_q;
  logic [DATA_W-1:0] bitsrc_q;
  logic [DATA_W-1:0] operand_q;
  logic [CCR_W-1:0]  ccr_q;
  logic [DATA_W-1:0] op_result;
  logic              op_zero;
  logic [STEP_W-1:0] op_step;
  logic              cmd_fire;
  logic              rd_fire;
  logic              ok_done;

  btc_decode u_decode (
    .opcode (cmd_opcode),
    .dec    (dec_in)
  );

  btc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .rd_valid  (mem_rd_valid),
    .wr_ready  (mem_wr_ready),
    .new_dec   (dec_in),
    .cur_dec   (dec_q),
    .cmd_ready (cmd_ready),
    .rd_ready  (mem_rd_ready),
    .wr_valid  (mem_wr_valid),
    .done      (done)
  );

  btc_bitop #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .BASE_HALF (BASE_HALF),
    .HI_EXTRA  (HI_EXTRA),
    .STEP_W    (STEP_W)
  ) u_bitop (
    .operand  (operand_q),
    .bitsrc   (bitsrc_q),
    .is_mem   (dec_q.is_mem),
    .is_clr   (dec_q.is_clr),
    .result   (op_result),
    .zero     (op_zero),
    .step_len (op_step)
  );

  assign cmd_fire = cmd_valid && cmd_ready;
  assign rd_fire  = mem_rd_valid && mem_rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q     <= '0;
      bitsrc_q  <= '0;
      operand_q <= '0;
      ccr_q     <= '0;
    end else if (cmd_fire) begin
      dec_q     <= dec_in;
      bitsrc_q  <= cmd_bitsrc;
      operand_q <= cmd_dreg;
      ccr_q     <= cmd_ccr;
    end else if (rd_fire) begin
      operand_q <= DATA_W'(mem_rd_data);
    end
  end

  assign ok_done     = done && !dec_q.illegal;
  assign illegal     = done && dec_q.illegal;
  assign mem_wr_data = op_result[BYTE_W-1:0];
  assign reg_wr_en   = ok_done && dec_q.is_clr && !dec_q.is_mem;
  assign reg_wr_idx  = dec_q.ea_reg;
  assign reg_wr_data = op_result;
  assign step_len    = ok_done ? op_step : '0;
  assign an_adj_en   = ok_done && ((dec_q.mode == MODE_POSTINC) || (dec_q.mode == MODE_PREDEC));
  assign an_adj_dec  = (dec_q.mode == MODE_PREDEC);
  assign an_adj_idx  = dec_q.ea_reg;

  always_comb begin
    ccr_out = ccr_q;
    if (ok_done) ccr_out[ZBIT] = op_zero;
  end
endmodule

// File: rtl/bit_clear_unit_chk.sv
module bit_clear_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_rd_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [BYTE_W-1:0] mem_wr_data,
  input logic              done,
  input logic              illegal,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [DATA_W-1:0] operand_q,
  input logic [4:0]        ccr_out,
  input logic [3:0]        step_len,
  input logic              an_adj_en
);
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data)));

  // R8
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, mem_rd_ready, mem_wr_valid, done}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R9
  side_effect_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || an_adj_en) |-> (done && !illegal));

  // R3
  single_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($countones(reg_wr_data ^ operand_q) <= 1));

  // R5
  zero_before_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && ($countones(reg_wr_data ^ operand_q) == 1)) |-> !ccr_out[2]);

  // R6
  step_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ((step_len == 4'd8) || (step_len == 4'd12)));

  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (step_len == 4'd0 && !reg_wr_en && !an_adj_en));
endmodule

bind bit_clear_unit bit_clear_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .mem_rd_ready (mem_rd_ready),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_data  (mem_wr_data),
  .done         (done),
  .illegal      (illegal),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_data  (reg_wr_data),
  .operand_q    (operand_q),
  .ccr_out      (ccr_out),
  .step_len     (step_len),
  .an_adj_en    (an_adj_en)
);

// File: tb/bit_clear_unit_tb.sv
module bit_clear_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_opcode = '0;
  logic [31:0] cmd_bitsrc = '0;
  logic [31:0] cmd_dreg = '0;
  logic [4:0]  cmd_ccr = '0;
  logic        mem_rd_valid = 1'b0;
  logic        mem_rd_ready;
  logic [7:0]  mem_rd_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [7:0]  mem_wr_data;
  logic        done;
  logic        illegal;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_idx;
  logic [31:0] reg_wr_data;
  logic [4:0]  ccr_out;
  logic [3:0]  step_len;
  logic        an_adj_en;
  logic        an_adj_dec;
  logic [2:0]  an_adj_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5ns clk = ~clk;

  bit_clear_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_bitsrc(cmd_bitsrc), .cmd_dreg(cmd_dreg), .cmd_ccr(cmd_ccr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .done(done), .illegal(illegal), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .ccr_out(ccr_out), .step_len(step_len),
    .an_adj_en(an_adj_en), .an_adj_dec(an_adj_dec), .an_adj_idx(an_adj_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one command; models the memory side with the given stall counts.
  task automatic run_op(input logic [15:0] opc, input logic [31:0] bsrc, input logic [31:0] dreg,
                        input logic [7:0] mbyte, input logic [4:0] ccr,
                        input int rdwait, input int wrwait);
    bit        dyn_hit, imm_hit, legal, is_clr, is_mem;
    int        n, reads, writes, cyc, rdw, wrw;
    logic [31:0] opnd, exp_res;
    bit        exp_z;
    logic [4:0] exp_ccr;
    int        exp_step;
    bit        rd_drv, wr_drv, rd_rdy_prev, wr_v_prev, got_done;
    logic [7:0] wr_data_prev, wdata;

    dyn_hit = ((opc & 16'hF1C0) == 16'h0100) || ((opc & 16'hF1C0) == 16'h0180);
    imm_hit = ((opc & 16'hFFC0) == 16'h0800) || ((opc & 16'hFFC0) == 16'h0880);
    legal   = (dyn_hit || imm_hit) && (opc[5:3] != 3'b001);
    is_clr  = opc[7];
    is_mem  = (opc[5:3] != 3'b000);
    n       = is_mem ? int'(bsrc % 8) : int'(bsrc % 32);
    opnd    = is_mem ? {24'h0, mbyte} : dreg;
    exp_z   = (opnd[n] == 1'b0);
    exp_res = is_clr ? (opnd & ~(32'h1 << n)) : opnd;
    exp_ccr = legal ? {ccr[4:3], exp_z, ccr[1:0]} : ccr;
    exp_step = (legal && is_clr && !is_mem) ? ((n >= 16) ? 12 : 8) : 0;

    chk(cmd_ready == 1'b1, "R8 cmd_ready idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_opcode = opc; cmd_bitsrc = bsrc; cmd_dreg = dreg; cmd_ccr = ccr;
    @(negedge clk);
    cmd_valid = 1'b0;
    reads = 0; writes = 0; rdw = rdwait; wrw = wrwait;
    rd_drv = 1'b0; wr_drv = 1'b0; rd_rdy_prev = 1'b0; wr_v_prev = 1'b0;
    wr_data_prev = '0; wdata = '0; got_done = 1'b0;
    for (cyc = 1; cyc < 40; cyc++) begin
      if (rd_drv && rd_rdy_prev) begin reads++; rd_drv = 1'b0; mem_rd_valid = 1'b0; end
      if (wr_drv && wr_v_prev) begin
        writes++; wdata = wr_data_prev; wr_drv = 1'b0; mem_wr_ready = 1'b0;
      end else if (wr_v_prev && mem_wr_valid) begin
        chk(mem_wr_data == wr_data_prev, "R8 wr data held", 32'(mem_wr_data), 32'(wr_data_prev));
      end
      if (done) begin got_done = 1'b1; break; end
      if (reg_wr_en || an_adj_en)
        chk(1'b0, "R9 strobe outside done", {30'h0, reg_wr_en, an_adj_en}, 32'h0);
      if (mem_rd_ready && !rd_drv) begin
        if (rdw == 0) begin mem_rd_valid = 1'b1; mem_rd_data = mbyte; rd_drv = 1'b1; end
        else rdw--;
      end
      if (mem_wr_valid && !wr_drv) begin
        if (wrw == 0) begin mem_wr_ready = 1'b1; wr_drv = 1'b1; end
        else wrw--;
      end
      rd_rdy_prev = mem_rd_ready; wr_v_prev = mem_wr_valid; wr_data_prev = mem_wr_data;
      @(negedge clk);
    end
    chk(got_done, "R9 done seen", 32'(got_done), 32'd1);
    if (!got_done) return;
    chk(illegal == !legal, "R1 R2 illegal flag", 32'(illegal), 32'(!legal));
    chk(ccr_out == exp_ccr, "R5 ccr_out", 32'(ccr_out), 32'(exp_ccr));
    chk(32'(step_len) == 32'(exp_step), "R6 step_len", 32'(step_len), 32'(exp_step));
    if (!legal || !is_mem)
      chk(cyc == 1, "R9 latency", 32'(cyc), 32'd1);
    if (!legal) begin
      chk(reads == 0 && writes == 0, "R2 no access", 32'(reads + writes), 32'd0);
      chk(!reg_wr_en && !an_adj_en, "R2 no write", {30'h0, reg_wr_en, an_adj_en}, 32'h0);
    end else if (!is_mem) begin
      chk(reg_wr_en == is_clr, "R3 reg_wr_en", 32'(reg_wr_en), 32'(is_clr));
      if (is_clr) begin
        chk(reg_wr_data == exp_res, "R3 reg_wr_data", reg_wr_data, exp_res);
        chk(reg_wr_idx == opc[2:0], "R3 reg_wr_idx", 32'(reg_wr_idx), 32'(opc[2:0]));
      end
      chk(!an_adj_en, "R7 no adjust", 32'(an_adj_en), 32'd0);
    end else begin
      chk(reads == 1, "R4 read count", 32'(reads), 32'd1);
      chk(writes == (is_clr ? 1 : 0), "R4 write count", 32'(writes), 32'(is_clr));
      if (is_clr) chk(wdata == exp_res[7:0], "R4 write byte", 32'(wdata), exp_res);
      chk(!reg_wr_en, "R4 no reg write", 32'(reg_wr_en), 32'd0);
      if (opc[5:3] == 3'b011 || opc[5:3] == 3'b100) begin
        chk(an_adj_en && an_adj_dec == (opc[5:3] == 3'b100) && an_adj_idx == opc[2:0],
            "R7 adjust", {28'h0, an_adj_en, an_adj_dec, 2'b0}, {28'h0, 1'b1, opc[5:3] == 3'b100, 2'b0});
      end else begin
        chk(!an_adj_en, "R7 no adjust", 32'(an_adj_en), 32'd0);
      end
    end
    @(negedge clk);
    chk(!done && cmd_ready, "R9 single pulse", {30'h0, done, cmd_ready}, 32'h1);
  endtask

  initial begin
    #2_000_000ns;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] base, opc;
    logic [2:0]  mm;
    logic [31:0] dv;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0 && !mem_wr_valid && !mem_rd_ready,
        "R9 reset state", {28'h0, cmd_ready, done, mem_wr_valid, mem_rd_ready}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 64; n++) begin
      for (int k = 0; k < 4; k++) begin
        base = (k == 0) ? 16'h0100 : (k == 1) ? 16'h0180 : (k == 2) ? 16'h0800 : 16'h0880;
        if (k < 2) base = base | 16'((n % 8) << 9);
        // R3 register destination, both values of the selected bit
        dv = (n % 3 == 0) ? 32'hFFFF_FFFF : 32'h9E37_79B9 * 32'(n + k + 1);
        run_op(base | 16'(n % 8), 32'(n), dv, 8'h00, 5'(n) ^ 5'h15, 0, 0);
        // R4 memory destination with stalls, R7 address modes
        case ((n + k) % 5)
          0: mm = 3'b010;
          1: mm = 3'b011;
          2: mm = 3'b100;
          3: mm = 3'b101;
          default: mm = 3'b111;
        endcase
        opc = base | {10'h0, mm, 3'(n + 1)};
        run_op(opc, 32'(n), 32'h0, 8'((n * 37 + k * 11) ^ 8'h5A), 5'(k) ^ 5'h0A, n % 3, (n + k) % 2);
      end
    end
    // R2 address register direct is illegal
    run_op(16'h0188 | 16'h0005, 32'd3, 32'hFFFF_FFFF, 8'hFF, 5'h1F, 0, 0);
    run_op(16'h0808, 32'd0, 32'h0, 8'h00, 5'h00, 0, 0);
    // R1 neighbouring encodings are rejected
    run_op(16'h0140, 32'd5, 32'hFFFF_FFFF, 8'hFF, 5'h1B, 0, 0);
    run_op(16'h0840, 32'd2, 32'h0, 8'h00, 5'h04, 0, 0);
    run_op(16'h4200, 32'd1, 32'h3, 8'h00, 5'h11, 0, 0);
    // R6 boundary: bit 15 and bit 16 on a register clear
    run_op(16'h0180, 32'd15, 32'h0000_8000, 8'h00, 5'h00, 0, 0);
    run_op(16'h0180, 32'd16, 32'h0001_0000, 8'h00, 5'h00, 0, 0);
    // R8 long write back-pressure
    run_op(16'h0890 | 16'h0002, 32'd7, 32'h0, 8'h80, 5'h1F, 3, 5);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule